// File: doc/BRIEF.md
# Rotate, Shift and Bit-Manipulation Unit

This is a purely combinational datapath slice for an 8-bit processor core of the classic accumulator-and-flags family. It carries out three kinds of work. The first is the four short accumulator rotates. The second is the eight rotate and shift operations of the prefixed group. The third is the bit test, bit set and bit clear operations on a bit chosen by a 3-bit index. The core's sequencer presents an operation code, the operand, the bit index, the current flag byte, an addressing-form code and an auxiliary byte. The unit returns the new data byte, the new flag byte and a flag-write enable within the same cycle.

Operand fetch, writeback and all sequencing stay in the surrounding core. The unit holds no state. When the flag-write enable is low, the flag output simply repeats the incoming flags, so the core can write them back or not without any further logic. Because the unit is combinational, it has no handshake: every output is a function of the present inputs only.

Top module: `rsb_unit`

## Requirements
- R1: The flag byte is laid out S=bit7, Z=bit6, Y=bit5, H=bit4, X=bit3, P/V=bit2, N=bit1, C=bit0. For the accumulator rotates (op codes 0 to 3), S, Z and P/V are copied from flags_i, H and N are cleared, Y and X are bits 5 and 3 of the result, and C is the bit shifted out.
- R2: Op 0 rotates left circularly and op 1 rotates right circularly, with the departing bit re-entering the vacated end. Op 2 rotates left and op 3 rotates right through the carry, with flags_i C entering the vacated end.
- R3: For the prefixed operations (op codes 4 to 11), the flags are set as follows. S is result bit 7. Z is set when the result is zero. Y and X are result bits 5 and 3. P/V is set when the result has an even number of ones. H and N are cleared. C is the bit shifted out.
- R4: Op 4 rotates left circularly, op 5 rotates right circularly, op 6 rotates left through carry and op 7 rotates right through carry.
- R5: Op 8 shifts left and fills bit 0 with 0. Op 10 shifts left and fills bit 0 with 1. Op 9 shifts right and keeps bit 7 unchanged. Op 11 shifts right and fills bit 7 with 0.
- R6: Op 12 tests bit bit_sel_i of operand_i and returns operand_i unchanged. It sets H, clears N and keeps C. It sets both Z and P/V exactly when the tested bit is 0. It sets S only when bit_sel_i is 7 and that bit is 1.
- R7: For op 12, Y and X are taken from bits 5 and 3 of operand_i when form_i is 0 (register form), and from bits 5 and 3 of aux_i when form_i is 1, 2 or 3 (memory or indexed forms).
- R8: Op 13 clears bit bit_sel_i and op 14 sets it, with the other bits passing unchanged. For these two op codes flags_o equals flags_i.
- R9: Op 15 is unused: result_o equals operand_i and flags_o equals flags_i.
- R10: flag_we_o is high for op codes 0 to 12 and low for op codes 13 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (0 to 15) |
| form_i | input | 2 | Addressing form: 0 register, 1 to 3 memory or indexed |
| operand_i | input | 8 | Data byte to operate on |
| bit_sel_i | input | 3 | Bit number for test, set and clear |
| flags_i | input | 8 | Current flag byte |
| aux_i | input | 8 | Byte supplying Y and X for memory-form bit test |
| result_o | output | 8 | Resulting data byte |
| flags_o | output | 8 | New flag byte (equals flags_i when not written) |
| flag_we_o | output | 1 | Flag-write enable |

## Verification
The bench drives every op code against operands chosen to hit the edges. All-zero operands check that Z and parity are set. Operands with only bit 7 or only bit 0 set check the carry-out and fill paths, and both carry-in values are used. A unit that fills the wrong end, or fills with the wrong value, shows up on the shifts: for example, an arithmetic right shift that drops the sign, or a left shift with the wrong fill in bit 0. A unit that recomputes S, Z or P/V on the accumulator rotates would overwrite the caller's flags.

The bit test is run on all eight indices, on all four forms and with differing operand and aux bytes. A design that took Y and X from the wrong byte, or that raised S for an index other than 7, would fail there. Set and clear are checked on every index to confirm that they leave the flags and the write enable alone.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

  typedef enum logic [3:0] {
    OP_RLCA = 4'd0,
    OP_RRCA = 4'd1,
    OP_RLA  = 4'd2,
    OP_RRA  = 4'd3,
    OP_RLC  = 4'd4,
    OP_RRC  = 4'd5,
    OP_RL   = 4'd6,
    OP_RR   = 4'd7,
    OP_SLA  = 4'd8,
    OP_SRA  = 4'd9,
    OP_SLL  = 4'd10,
    OP_SRL  = 4'd11,
    OP_BIT  = 4'd12,
    OP_RES  = 4'd13,
    OP_SET  = 4'd14,
    OP_NOP  = 4'd15
  } rsb_op_e;

  // flag byte bit positions
  localparam int FL_S = 7;
  localparam int FL_Z = 6;
  localparam int FL_Y = 5;
  localparam int FL_H = 4;
  localparam int FL_X = 3;
  localparam int FL_P = 2;
  localparam int FL_N = 1;
  localparam int FL_C = 0;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_ONE  = 2'd1,
    FILL_OUT  = 2'd2,
    FILL_CY   = 2'd3
  } rsb_fill_e;

endpackage

// File: rtl/rsb_shift.sv
module rsb_shift
  import rsb_pkg::*;
#(
  parameter int W = 8
) (
  input  rsb_op_e        op_i,
  input  logic [W-1:0]   val_i,
  input  logic           cy_i,
  output logic [W-1:0]   res_o,
  output logic           cy_o,
  output logic           acc_form_o
);

  logic      go_left;
  logic      keep_sign;
  rsb_fill_e fill_sel;
  logic      fill_bit;
  logic      out_bit;

  // decode direction and fill source
  always_comb begin
    go_left    = 1'b0;
    keep_sign  = 1'b0;
    fill_sel   = FILL_ZERO;
    acc_form_o = 1'b0;
    case (op_i)
      OP_RLCA: begin go_left = 1'b1; fill_sel = FILL_OUT; acc_form_o = 1'b1; end
      OP_RRCA: begin                 fill_sel = FILL_OUT; acc_form_o = 1'b1; end
      OP_RLA:  begin go_left = 1'b1; fill_sel = FILL_CY;  acc_form_o = 1'b1; end
      OP_RRA:  begin                 fill_sel = FILL_CY;  acc_form_o = 1'b1; end
      OP_RLC:  begin go_left = 1'b1; fill_sel = FILL_OUT; end
      OP_RRC:  begin                 fill_sel = FILL_OUT; end
      OP_RL:   begin go_left = 1'b1; fill_sel = FILL_CY;  end
      OP_RR:   begin                 fill_sel = FILL_CY;  end
      OP_SLA:  begin go_left = 1'b1; fill_sel = FILL_ZERO; end
      OP_SLL:  begin go_left = 1'b1; fill_sel = FILL_ONE;  end
      OP_SRA:  begin                 keep_sign = 1'b1;     end
      OP_SRL:  begin                 fill_sel = FILL_ZERO; end
      default: begin end
    endcase
  end

  always_comb begin
    out_bit = go_left ? val_i[W-1] : val_i[0];
    case (fill_sel)
      FILL_ONE: fill_bit = 1'b1;
      FILL_OUT: fill_bit = out_bit;
      FILL_CY:  fill_bit = cy_i;
      default:  fill_bit = 1'b0;
    endcase
    if (keep_sign) fill_bit = val_i[W-1];
  end

  always_comb begin
    if (go_left) res_o = {val_i[W-2:0], fill_bit};
    else         res_o = {fill_bit, val_i[W-1:1]};
    cy_o = out_bit;
  end

  // arithmetic right shift must keep the sign bit
  always_comb begin
    if (!$isunknown({op_i, val_i, cy_i}) && op_i == OP_SRA) begin
      p_sra_sign_r5: assert (res_o[W-1] == val_i[W-1] && cy_o == val_i[0]);
    end
  end

endmodule

// File: rtl/rsb_flagcalc.sv
module rsb_flagcalc
  import rsb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] res_i,
  input  logic         cy_i,
  input  logic         acc_form_i,
  input  logic [7:0]   flags_i,
  output logic [7:0]   flags_o
);

  logic res_zero;
  logic res_even;

  assign res_zero = (res_i == '0);
  assign res_even = ~^res_i;

  always_comb begin
    flags_o        = '0;
    flags_o[FL_Y]  = res_i[5];
    flags_o[FL_X]  = res_i[3];
    flags_o[FL_C]  = cy_i;
    if (acc_form_i) begin
      flags_o[FL_S] = flags_i[FL_S];
      flags_o[FL_Z] = flags_i[FL_Z];
      flags_o[FL_P] = flags_i[FL_P];
    end else begin
      flags_o[FL_S] = res_i[W-1];
      flags_o[FL_Z] = res_zero;
      flags_o[FL_P] = res_even;
    end
  end

  // H and N are always clear for this group
  always_comb begin
    if (!$isunknown({res_i, cy_i, acc_form_i, flags_i})) begin
      p_hn_clear_r3: assert (flags_o[FL_H] == 1'b0 && flags_o[FL_N] == 1'b0);
    end
  end

endmodule

// File: rtl/rsb_bitop.sv
module rsb_bitop
  import rsb_pkg::*;
#(
  parameter int W     = 8,
  parameter int IDX_W = $clog2(W)
) (
  input  rsb_op_e          op_i,
  input  logic [W-1:0]     val_i,
  input  logic [IDX_W-1:0] sel_i,
  input  logic [1:0]       form_i,
  input  logic [7:0]       aux_i,
  input  logic [7:0]       flags_i,
  output logic [W-1:0]     res_o,
  output logic [7:0]       flags_o
);

  logic [W-1:0] mask;
  logic [W-1:0] hit;
  logic [7:0]   xy_src;
  logic         tested;

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign mask[i] = (sel_i == IDX_W'(i));
    assign hit[i]  = mask[i] & val_i[i];
  end

  assign tested = |hit;
  assign xy_src = (form_i == 2'd0) ? val_i[7:0] : aux_i;

  always_comb begin
    case (op_i)
      OP_RES:  res_o = val_i & ~mask;
      OP_SET:  res_o = val_i | mask;
      default: res_o = val_i;
    endcase
  end

  always_comb begin
    flags_o        = '0;
    flags_o[FL_S]  = hit[W-1];
    flags_o[FL_Z]  = ~tested;
    flags_o[FL_Y]  = xy_src[5];
    flags_o[FL_H]  = 1'b1;
    flags_o[FL_X]  = xy_src[3];
    flags_o[FL_P]  = ~tested;
    flags_o[FL_C]  = flags_i[FL_C];
  end

  // exactly one bit is selected; set/clear alter only that bit
  always_comb begin
    if (!$isunknown({op_i, val_i, sel_i})) begin
      p_mask_onehot_r8: assert ($countones(mask) == 1);
      p_other_bits_r8: assert (((res_o ^ val_i) & ~mask) == '0);
    end
  end

endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
  import rsb_pkg::*;
#(
  parameter int W     = 8,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [3:0]       op_i,
  input  logic [1:0]       form_i,
  input  logic [W-1:0]     operand_i,
  input  logic [IDX_W-1:0] bit_sel_i,
  input  logic [7:0]       flags_i,
  input  logic [7:0]       aux_i,
  output logic [W-1:0]     result_o,
  output logic [7:0]       flags_o,
  output logic             flag_we_o
);

  rsb_op_e      op;
  logic [W-1:0] sh_res;
  logic         sh_cy;
  logic         sh_acc;
  logic [7:0]   sh_flags;
  logic [W-1:0] bo_res;
  logic [7:0]   bo_flags;
  logic         is_shift;
  logic         is_bit;

  assign op       = rsb_op_e'(op_i);
  assign is_shift = (op_i <= 4'(OP_SRL));
  assign is_bit   = (op == OP_BIT);

  rsb_shift #(.W(W)) u_shift (
    .op_i       (op),
    .val_i      (operand_i),
    .cy_i       (flags_i[FL_C]),
    .res_o      (sh_res),
    .cy_o       (sh_cy),
    .acc_form_o (sh_acc)
  );

  rsb_flagcalc #(.W(W)) u_flags (
    .res_i      (sh_res),
    .cy_i       (sh_cy),
    .acc_form_i (sh_acc),
    .flags_i    (flags_i),
    .flags_o    (sh_flags)
  );

  rsb_bitop #(.W(W), .IDX_W(IDX_W)) u_bitop (
    .op_i    (op),
    .val_i   (operand_i),
    .sel_i   (bit_sel_i),
    .form_i  (form_i),
    .aux_i   (aux_i),
    .flags_i (flags_i),
    .res_o   (bo_res),
    .flags_o (bo_flags)
  );

  always_comb begin
    result_o  = is_shift ? sh_res : bo_res;
    flag_we_o = is_shift | is_bit;
    if (is_shift)    flags_o = sh_flags;
    else if (is_bit) flags_o = bo_flags;
    else             flags_o = flags_i;
  end

  always_comb begin
    if (!$isunknown({op_i, form_i, operand_i, bit_sel_i, flags_i, aux_i})) begin
      if (op_i <= 4'd3) begin
        p_acc_keep_r1: assert (flags_o[FL_S] == flags_i[FL_S] &&
                               flags_o[FL_Z] == flags_i[FL_Z] &&
                               flags_o[FL_P] == flags_i[FL_P]);
      end
      if (op_i >= 4'd4 && op_i <= 4'd11) begin
        p_zero_flag_r3: assert (flags_o[FL_Z] == (result_o == '0));
      end
      if (op_i == 4'd12) begin
        p_bit_zp_r6: assert (flags_o[FL_Z] == flags_o[FL_P] && result_o == operand_i);
      end
      if (op_i >= 4'd13) begin
        p_quiet_flags_r10: assert (!flag_we_o && flags_o == flags_i);
      end
    end
  end

endmodule

// File: tb/rsb_unit_tb.sv
module rsb_unit_tb;

  logic       clk = 1'b0;
  logic [3:0] op;
  logic [1:0] form;
  logic [7:0] opnd;
  logic [2:0] bsel;
  logic [7:0] fin;
  logic [7:0] aux;
  logic [7:0] res;
  logic [7:0] fout;
  logic       we;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  rsb_unit u_dut (
    .op_i      (op),
    .form_i    (form),
    .operand_i (opnd),
    .bit_sel_i (bsel),
    .flags_i   (fin),
    .aux_i     (aux),
    .result_o  (res),
    .flags_o   (fout),
    .flag_we_o (we)
  );

  function automatic int ones(input int v);
    int n = 0;
    for (int k = 0; k < 8; k++) n += (v >> k) & 1;
    return n;
  endfunction

  // behavioural reference
  function automatic void model(input int o, input int a, input int bs, input int f,
                                input int fm, input int x,
                                output int r, output int fl, output int w);
    int c = f & 1;
    int out = 0;
    int t;
    int src;
    r = a; fl = f; w = 1;
    case (o)
      0, 4:  begin r = ((a << 1) | (a >> 7)) & 255; out = a >> 7; end
      1, 5:  begin r = ((a >> 1) | (a << 7)) & 255; out = a & 1; end
      2, 6:  begin r = ((a << 1) | c) & 255;        out = a >> 7; end
      3, 7:  begin r = (a >> 1) | (c << 7);         out = a & 1; end
      8:     begin r = (a << 1) & 255;              out = a >> 7; end
      9:     begin r = (a >> 1) | (a & 128);        out = a & 1; end
      10:    begin r = ((a << 1) | 1) & 255;        out = a >> 7; end
      11:    begin r = a >> 1;                      out = a & 1; end
      default: begin end
    endcase
    if (o < 4) fl = (f & 8'hC4) | (r & 8'h28) | out;
    else if (o < 12)
      fl = (r & 128) | ((r == 0) ? 64 : 0) | (r & 8'h28) |
           (((ones(r) % 2) == 0) ? 4 : 0) | out;
    else if (o == 12) begin
      t   = (a >> bs) & 1;
      src = (fm == 0) ? a : x;
      fl  = (f & 1) | 16 | (src & 8'h28) | (t ? 0 : 8'h44) | ((bs == 7 && t == 1) ? 128 : 0);
    end else begin
      w = 0;
      if (o == 13) r = a & ~(1 << bs) & 255;
      if (o == 14) r = a | (1 << bs);
    end
  endfunction

  function automatic string res_tag(input int o);
    if (o < 4)   return "R2";
    if (o < 8)   return "R4";
    if (o < 12)  return "R5";
    if (o == 12) return "R6";
    if (o < 15)  return "R8";
    return "R9";
  endfunction

  function automatic string flag_tag(input int o, input int fm);
    if (o < 4)   return "R1";
    if (o < 12)  return "R3";
    if (o == 12) return (fm != 0) ? "R7" : "R6";
    if (o < 15)  return "R8";
    return "R9";
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s op=%0d a=%02h sel=%0d f=%02h form=%0d: got %02h expected %02h",
               tag, what, op, opnd, bsel, fin, form, act, exp);
    end
  endtask

  task automatic run(input int o, input int a, input int bs, input int f,
                     input int fm, input int x);
    int er, ef, ew;
    @(posedge clk);
    op = 4'(o); opnd = 8'(a); bsel = 3'(bs); fin = 8'(f); form = 2'(fm); aux = 8'(x);
    @(negedge clk);
    model(o, a, bs, f, fm, x, er, ef, ew);
    check(res_tag(o), int'(res), er, "result");
    check(flag_tag(o, fm), int'(fout), ef, "flags");
    check("R10", int'(we), ew, "flag_we");
  endtask

  initial begin
    int pats[8] = '{8'h00, 8'h80, 8'h01, 8'hFF, 8'h55, 8'hAA, 8'h28, 8'h7E};
    op = '0; form = '0; opnd = '0; bsel = '0; fin = '0; aux = '0;
    // quiet state at start: op 15 passes everything through
    run(15, 8'h00, 0, 8'h00, 0, 8'h00);
    // every op against edge operands and both carry values (R1..R5, R8, R9, R10)
    for (int o = 0; o < 16; o++)
      for (int p = 0; p < 8; p++)
        for (int cy = 0; cy < 2; cy++)
          run(o, pats[p], p, (cy ? 8'hC5 : 8'h02) , 0, 8'h00);
    // bit test on all indices and forms, operand and aux differing (R6, R7)
    for (int bs = 0; bs < 8; bs++)
      for (int fm = 0; fm < 4; fm++) begin
        run(12, 8'h00, bs, 8'h01, fm, 8'hFF);
        run(12, 8'hFF, bs, 8'h00, fm, 8'h00);
        run(12, 8'h28, bs, 8'hFE, fm, 8'h08);
      end
    // set and clear on every index (R8)
    for (int bs = 0; bs < 8; bs++) begin
      run(13, 8'hFF, bs, 8'h5A, 1, 8'h00);
      run(14, 8'h00, bs, 8'hA5, 2, 8'h00);
    end
    // mixed random sweep across all ops
    for (int k = 0; k < 600; k++)
      run(int'($urandom_range(15, 0)), int'($urandom_range(255, 0)),
          int'($urandom_range(7, 0)), int'($urandom_range(255, 0)),
          int'($urandom_range(3, 0)), int'($urandom_range(255, 0)));
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule